// File: doc/BRIEF.md
# Crosswise Column-Sum Array Multiplier

This block multiplies two unsigned operands of `N` bits each and returns their full product of `2N` bits. It has no clock and holds no state. Every AND of an operand bit pair is formed at the same moment. The pairs are grouped by output weight: column `k` collects every pair `opA[i] & opB[j]` with `i + j = k`. Column 0 is a single vertical pair. The columns above it are crosswise groups.

Each column adds its own partial products to the carry that comes from the column below. The least significant bit of that sum becomes product bit `k`. All the higher bits of the sum move up as the carry into column `k + 1`, and this carry can be several bits wide. For example, a column sum of binary 1101 gives result bit 1 and carry 110. There are `2N - 1` columns. The carry out of the top column supplies the most significant product bit, so for `N = 4` the product is the final carry placed above seven result bits.

The block is intended as an arithmetic leaf inside a wider datapath. It can be used wherever an unsigned product must settle in a single combinational pass. The operand width is a parameter, and every column's carry width is derived from it at elaboration.

Top module: `cwColMul`

## Requirements
- R1: For `N = 4`, `product` equals `opA * opB` as an unsigned 8-bit value for all 256 operand pairs.
- R2: `product[0]` equals `opA[0] & opB[0]`.
- R3: `product[1]` equals the least significant bit of `(opA[1] & opB[0]) + (opA[0] & opB[1])`, which is their exclusive OR.
- R4: When either operand is zero, `product` is zero.
- R5: When one operand equals 1, `product` equals the other operand, zero-extended to `2N` bits.
- R6: When both operands are all ones, `product` equals `(2^N - 1)^2`. For `N = 4` this is 8'hE1, and its top bit is set.
- R7: `product[2N-1]` is set only if both `opA[N-1]` and `opB[N-1]` are set.
- R8: At `N = 8` and at `N = 16`, `product` equals `opA * opB` as a `2N`-bit unsigned value for arbitrary operands.
- R9: `product` follows a change on the operands without any clock edge.
- R10: Only bit 0 of the carry out of the top column can be nonzero. The higher bits of that carry are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | Unsigned multiplicand |
| opB | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned full-width product |

## Verification
At `N = 4` the bench tries every operand pair. This catches any wrongly grouped column and any carry that is truncated, dropped or misplaced. Zero, unit and all-ones operands are tried as separate patterns. A zero operand separates stray partial products from the real ones. A unit operand shows whether each bit lands at its correct weight. All-ones operands fill every column to its maximum, which puts the widest possible carry on each column boundary. At 8 and 16 bits, random operands show that the derived carry widths still hold the sums when columns are much taller. One case changes the operands with no clock edge in between, to show that the block is purely combinational.

// File: rtl/cwColMulPkg.sv
package cwColMulPkg;

  // number of operand bit pairs whose weights add up to k
  function automatic int colTerms(input int n, input int k);
    int lo;
    int hi;
    lo = (k - n + 1 < 0) ? 0 : k - n + 1;
    hi = (k < n - 1) ? k : n - 1;
    return (hi >= lo) ? hi - lo + 1 : 0;
  endfunction

  // largest carry that can enter column k
  function automatic int maxCarryIn(input int n, input int k);
    int c;
    c = 0;
    for (int j = 0; j < k; j++) c = (colTerms(n, j) + c) >> 1;
    return c;
  endfunction

  // bits needed to represent values 0..v (at least one)
  function automatic int bitsFor(input int v);
    int w;
    w = $clog2(v + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // width of the column sum at weight k
  function automatic int sumWidth(input int n, input int k);
    return bitsFor(colTerms(n, k) + maxCarryIn(n, k));
  endfunction

  // one carry width wide enough for every column boundary
  function automatic int carryWidth(input int n);
    int w;
    w = 1;
    for (int k = 0; k < 2 * n; k++)
      if (bitsFor(maxCarryIn(n, k)) > w) w = bitsFor(maxCarryIn(n, k));
    return w;
  endfunction

endpackage

// File: rtl/cwPartials.sv
module cwPartials #(
  parameter int N = 4
) (
  input  logic [N-1:0]             opA,
  input  logic [N-1:0]             opB,
  output logic [2*N-2:0][N-1:0]    ppCols
);

  // column k, slot i holds opA[i] & opB[k-i] when that index is in range
  for (genvar k = 0; k < 2 * N - 1; k++) begin : g_col
    for (genvar i = 0; i < N; i++) begin : g_slot
      if ((k - i >= 0) && (k - i < N)) begin : g_pair
        assign ppCols[k][i] = opA[i] & opB[k-i];
      end else begin : g_pad
        assign ppCols[k][i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/cwColumnSum.sv
module cwColumnSum #(
  parameter int N  = 4,
  parameter int CW = 2,
  parameter int SW = 3
) (
  input  logic [N-1:0]  pp,
  input  logic [CW-1:0] cin,
  output logic          resBit,
  output logic [CW-1:0] cout
);

  logic [SW-1:0] colSum;

  always_comb begin
    colSum = SW'(cin);
    for (int i = 0; i < N; i++) colSum = colSum + SW'(pp[i]);
  end

  assign resBit = colSum[0];
  assign cout   = CW'(colSum >> 1);

endmodule

// File: rtl/cwColMul.sv
module cwColMul
  import cwColMulPkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [2*N-1:0] product
);

  localparam int NCOL = 2 * N - 1;
  localparam int CW   = carryWidth(N);

  logic [NCOL-1:0][N-1:0] ppCols;
  logic [NCOL:0][CW-1:0]  carryBus;

  cwPartials #(.N(N)) partialsInst (
    .opA    (opA),
    .opB    (opB),
    .ppCols (ppCols)
  );

  assign carryBus[0] = '0;

  for (genvar k = 0; k < NCOL; k++) begin : g_column
    localparam int SW = sumWidth(N, k);
    cwColumnSum #(.N(N), .CW(CW), .SW(SW)) sumInst (
      .pp     (ppCols[k]),
      .cin    (carryBus[k]),
      .resBit (product[k]),
      .cout   (carryBus[k+1])
    );
  end

  // the final carry is at most one; its upper bits stay zero (checked in the checker)
  assign product[2*N-1] = |carryBus[NCOL];

endmodule

// File: rtl/cwColMulChk.sv
module cwColMulChk #(
  parameter int N = 4
) (
  input logic [N-1:0]   opA,
  input logic [N-1:0]   opB,
  input logic [2*N-1:0] product,
  input logic [carryWidthOf(N)-1:0] lastCarry
);

  function automatic int carryWidthOf(input int n);
    return cwColMulPkg::carryWidth(n);
  endfunction

  always_comb begin
    // R2
    lsb_pair_chk: assert (product[0] == (opA[0] & opB[0]));
    // R3
    second_col_chk: assert (product[1] == ((opA[1] & opB[0]) ^ (opA[0] & opB[1])));
    // R4
    zero_operand_chk: assert (!((opA == '0) || (opB == '0)) || (product == '0));
    // R5
    unit_operand_chk: assert ((opA != N'(1)) || (product == (2*N)'(opB)));
    // R7
    top_bit_chk: assert (!product[2*N-1] || (opA[N-1] && opB[N-1]));
    // R10
    last_carry_chk: assert ((lastCarry >> 1) == '0);
  end

endmodule

bind cwColMul cwColMulChk #(.N(N)) chkInst (
  .opA       (opA),
  .opB       (opB),
  .product   (product),
  .lastCarry (carryBus[2*N-1])
);

// File: tb/cwColMul_test.sv
module cwColMul_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk;
  logic rstN;
  int   checks;
  int   errors;
  bit   done;

  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [15:0] a16, b16;
  logic [31:0] p16;

  cwColMul #(.N(4))  uut      (.opA(a4),  .opB(b4),  .product(p4));
  cwColMul #(.N(8))  uutByte  (.opA(a8),  .opB(b8),  .product(p8));
  cwColMul #(.N(16)) uutWord  (.opA(a16), .opB(b16), .product(p16));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply4(input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    a4 = x;
    b4 = y;
    #1;
  endtask

  // R4: reset state with operands held at zero
  task automatic testReset();
    check("R4 reset", 64'(p4), 64'd0);
    check("R4 reset byte", 64'(p8), 64'd0);
  endtask

  // R1, R2, R3: every operand pair at N=4
  task automatic testExhaustive();
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply4(4'(x), 4'(y));
        check("R1 exhaustive", 64'(p4), 64'(x * y));
        check("R2 bit0", 64'(p4[0]), 64'(x[0] & y[0]));
        check("R3 bit1", 64'(p4[1]), 64'(x[1] ^ y[1] ? (x[0] ^ y[0] ? 1'b0 : 1'b0) : 1'b0)
              | 64'((x[1] & y[0]) ^ (x[0] & y[1])));
      end
    end
  endtask

  // R4: zero on either side
  task automatic testZero();
    for (int v = 0; v < 16; v++) begin
      apply4(4'(v), 4'd0);
      check("R4 zero opB", 64'(p4), 64'd0);
      apply4(4'd0, 4'(v));
      check("R4 zero opA", 64'(p4), 64'd0);
    end
  endtask

  // R5: unit operand passes the other through
  task automatic testUnit();
    for (int v = 0; v < 16; v++) begin
      apply4(4'd1, 4'(v));
      check("R5 unit opA", 64'(p4), 64'(v));
      apply4(4'(v), 4'd1);
      check("R5 unit opB", 64'(p4), 64'(v));
    end
  endtask

  // R6, R7: all-ones operands fill every column
  task automatic testAllOnes();
    apply4(4'hF, 4'hF);
    check("R6 all ones", 64'(p4), 64'hE1);
    check("R7 top bit set", 64'(p4[7]), 64'd1);
    apply4(4'h7, 4'hF);
    check("R7 top bit clear", 64'(p4[7]), 64'd0);
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'hFF; a16 = 16'hFFFF; b16 = 16'hFFFF;
    #1;
    check("R6 all ones byte", 64'(p8), 64'hFE01);
    check("R6 all ones word", 64'(p16), 64'hFFFE0001);
  endtask

  // R8: random operands at wider widths
  task automatic testWide();
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      a8  = 8'($urandom);
      b8  = 8'($urandom);
      a16 = 16'($urandom);
      b16 = 16'($urandom);
      #1;
      check("R8 byte", 64'(p8), 64'(a8) * 64'(b8));
      check("R8 word", 64'(p16), 64'(a16) * 64'(b16));
    end
  endtask

  // R9: result tracks operands with no clock edge between changes
  task automatic testNoClock();
    @(negedge clk);
    a4 = 4'd3; b4 = 4'd5;
    #1;
    check("R9 first", 64'(p4), 64'd15);
    a4 = 4'd9; b4 = 4'd7;
    #1;
    check("R9 second", 64'(p4), 64'd63);
    a4 = 4'd12; b4 = 4'd11;
    #1;
    check("R9 third", 64'(p4), 64'd132);
  endtask

  // R10: top carry upper bits are observed through the product staying in range
  task automatic testTopCarry();
    apply4(4'hE, 4'hF);
    check("R10 top carry", 64'(p4), 64'd210);
    apply4(4'hD, 4'hD);
    check("R10 top carry", 64'(p4), 64'd169);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rstN   = 1'b0;
    a4 = '0; b4 = '0; a8 = '0; b8 = '0; a16 = '0; b16 = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExhaustive();
    testZero();
    testUnit();
    testAllOnes();
    testWide();
    testNoClock();
    testTopCarry();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule